// File: doc/BRIEF.md
# Byte lane extract, insert and mask unit

This unit handles byte work for a core whose memory path moves whole 64-bit words only. Software fetches the containing word, then uses this unit to pull one byte out of a register, to place a byte into a chosen lane, or to clear a lane. An OR of the cleared word with the placed byte merges a new byte into the word before it is stored back. Lane selection uses only the three low bits of an address operand, so the cache path needs no shift-and-mask logic.

The same unit also performs register-to-register conditional moves and scaled add/subtract for address arithmetic. A conditional move always presents the source on the result, and the write-enable output tells the register file whether to write it. Every operation is taken from the inputs at one rising clock edge and appears on the registered outputs right after that edge.

Top module: `bxu_top`

## Requirements
- R1: While rst_ni is low, result_o is 0 and wen_o is 0, and the clear takes effect without waiting for a clock edge.
- R2: Opcode 0 (extract) gives result_o = byte lane a_i[2:0] of b_i in bits [7:0], with bits [63:8] zero. Lane n is bits [8n+7:8n], so lane 0 is bits [7:0] and lane 7 is bits [63:56].
- R3: Opcode 1 (mask) gives b_i with lane a_i[2:0] cleared to zero and every other lane unchanged.
- R4: Opcode 2 (insert) gives b_i[7:0] placed in lane a_i[2:0], with every other lane zero.
- R5: Opcode 3 (merge) gives a_i | b_i.
- R6: Opcodes 4 to 11 are conditional moves: result_o = b_i, and wen_o is 1 only when c_i passes the test for the opcode: 4 c==0, 5 c!=0, 6 c<0, 7 c>=0, 8 c<=0, 9 c>0 (all signed), 10 c odd, 11 c even.
- R7: For every opcode outside 4 to 11, wen_o is 1.
- R8: Opcodes 12 to 15 are scaled arithmetic, modulo 2^64: 12 gives 4a+b, 13 gives 8a+b, 14 gives 4a-b, 15 gives 8a-b.
- R9: Inputs are sampled on a rising clock edge; result_o and wen_o change only right after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | Address or first operand; bits [2:0] select the lane |
| b_i | input | 64 | Data or second operand; conditional-move source |
| c_i | input | 64 | Condition operand for conditional moves |
| result_o | output | 64 | Registered result |
| wen_o | output | 1 | Registered destination write-enable |

## Verification
The bench builds the unit at its default values: 64-bit operands split into eight 8-bit lanes, with scale shifts of two and three. With those values, every lane offset from 0 through 7 can be reached, including the top lane and the sign bit 63 that the signed condition tests read. A wrap past 2^64 is also reachable in the scaled operations. Hand-computed vectors cover each opcode and each condition, both true and false. A reference model then checks all sixteen opcodes with random operands, rotating through all eight lane offsets.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_EXT      = 4'd0,
    OP_MSK      = 4'd1,
    OP_INS      = 4'd2,
    OP_OR       = 4'd3,
    OP_CMOV_EQ  = 4'd4,
    OP_CMOV_NE  = 4'd5,
    OP_CMOV_LT  = 4'd6,
    OP_CMOV_GE  = 4'd7,
    OP_CMOV_LE  = 4'd8,
    OP_CMOV_GT  = 4'd9,
    OP_CMOV_ODD = 4'd10,
    OP_CMOV_EVN = 4'd11,
    OP_S4ADD    = 4'd12,
    OP_S8ADD    = 4'd13,
    OP_S4SUB    = 4'd14,
    OP_S8SUB    = 4'd15
  } op_e;

  function automatic logic is_cmov(logic [OP_W-1:0] op);
    return (op[3:2] == 2'b01) || (op[3:2] == 2'b10);
  endfunction

  function automatic logic is_scaled(logic [OP_W-1:0] op);
    return op[3:2] == 2'b11;
  endfunction

endpackage

// File: rtl/bxu_lane.sv
module bxu_lane #(
  parameter int XLEN   = 64,
  parameter int LANE_W = 8,
  localparam int N_LANES = XLEN / LANE_W,
  localparam int SEL_W   = $clog2(N_LANES)
) (
  input  logic [XLEN-1:0]   data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [LANE_W-1:0] ext_o,
  output logic [XLEN-1:0]   msk_o,
  output logic [XLEN-1:0]   ins_o
);

  logic [N_LANES-1:0] dec;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign dec[g] = (sel_i == SEL_W'(g));
    assign msk_o[g*LANE_W +: LANE_W] = dec[g] ? '0 : data_i[g*LANE_W +: LANE_W];
    assign ins_o[g*LANE_W +: LANE_W] = dec[g] ? data_i[LANE_W-1:0] : '0;
  end

  always_comb begin
    ext_o = '0;
    for (int i = 0; i < N_LANES; i++) begin
      if (dec[i]) ext_o = data_i[i*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/bxu_cond.sv
module bxu_cond
  import bxu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] c_i,
  output logic            pass_o
);

  logic zero, neg;

  assign zero = (c_i == '0);
  assign neg  = c_i[XLEN-1];

  always_comb begin
    unique case (op_e'(op_i))
      OP_CMOV_EQ:  pass_o = zero;
      OP_CMOV_NE:  pass_o = !zero;
      OP_CMOV_LT:  pass_o = neg;
      OP_CMOV_GE:  pass_o = !neg;
      OP_CMOV_LE:  pass_o = neg | zero;
      OP_CMOV_GT:  pass_o = !neg && !zero;
      OP_CMOV_ODD: pass_o = c_i[0];
      OP_CMOV_EVN: pass_o = !c_i[0];
      default:     pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bxu_scale.sv
module bxu_scale #(
  parameter int XLEN     = 64,
  parameter int SCALE_LO = 2,
  parameter int SCALE_HI = 3
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            hi_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o
);

  logic [XLEN-1:0] scaled;

  assign scaled = hi_i ? (a_i << SCALE_HI) : (a_i << SCALE_LO);
  assign sum_o  = sub_i ? (scaled - b_i) : (scaled + b_i);

endmodule

// File: rtl/bxu_top.sv
module bxu_top
  import bxu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int LANE_W   = 8,
  parameter int SCALE_LO = 2,
  parameter int SCALE_HI = 3,
  localparam int N_LANES = XLEN / LANE_W,
  localparam int SEL_W   = $clog2(N_LANES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic [XLEN-1:0] result_o,
  output logic            wen_o
);

  logic [LANE_W-1:0] ext;
  logic [XLEN-1:0]   msk, ins, sum, res_d;
  logic              pass, wen_d;

  bxu_lane #(.XLEN(XLEN), .LANE_W(LANE_W)) u_lane (
    .data_i (b_i),
    .sel_i  (a_i[SEL_W-1:0]),
    .ext_o  (ext),
    .msk_o  (msk),
    .ins_o  (ins)
  );

  bxu_cond #(.XLEN(XLEN)) u_cond (
    .op_i   (op_i),
    .c_i    (c_i),
    .pass_o (pass)
  );

  bxu_scale #(.XLEN(XLEN), .SCALE_LO(SCALE_LO), .SCALE_HI(SCALE_HI)) u_scale (
    .a_i   (a_i),
    .b_i   (b_i),
    .hi_i  (op_i[0]),
    .sub_i (op_i[1]),
    .sum_o (sum)
  );

  always_comb begin
    wen_d = 1'b1;
    if (is_cmov(op_i)) begin
      res_d = b_i;
      wen_d = pass;
    end else if (is_scaled(op_i)) begin
      res_d = sum;
    end else begin
      unique case (op_e'(op_i))
        OP_EXT:  res_d = {{(XLEN-LANE_W){1'b0}}, ext};
        OP_MSK:  res_d = msk;
        OP_INS:  res_d = ins;
        default: res_d = a_i | b_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wen_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      wen_o    <= wen_d;
    end
  end

endmodule

// File: rtl/bxu_chk.sv
module bxu_chk
  import bxu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LANE_W = 8,
  localparam int N_LANES = XLEN / LANE_W,
  localparam int SEL_W   = $clog2(N_LANES)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] c_i,
  input logic [XLEN-1:0] result_o,
  input logic            wen_o
);

  logic [N_LANES-1:0] lane_nz;

  for (genvar g = 0; g < N_LANES; g++) begin : g_nz
    assign lane_nz[g] = |result_o[g*LANE_W +: LANE_W];
  end

  p_rst_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0) && !wen_o);

  p_ext_high_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_EXT |=> result_o[XLEN-1:LANE_W] == '0);

  p_msk_lane_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MSK |=> result_o[$past(a_i[SEL_W-1:0])*LANE_W +: LANE_W] == '0);

  p_ins_one_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_INS |=> $countones(lane_nz) <= 1);

  p_or_merge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_OR |=> result_o == ($past(a_i) | $past(b_i)));

  p_cmov_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmov(op_i) |=> result_o == $past(b_i));

  p_cmov_eq_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMOV_EQ) && (c_i == '0) |=> wen_o);

  p_wen_alu_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_cmov(op_i) |=> wen_o);

endmodule

bind bxu_top bxu_chk #(.XLEN(XLEN), .LANE_W(LANE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .c_i      (c_i),
  .result_o (result_o),
  .wen_o    (wen_o)
);

// File: tb/sim_bxu_top.sv
`timescale 1ns/1ps
module sim_bxu_top;
  import bxu_pkg::*;

  localparam int CLK_NS = 20;
  localparam int N_VEC  = 20;
  localparam int N_RAND = 480;

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    logic [63:0] exp;
    logic        wen;
  } vec_t;

  localparam logic [63:0] PAT = 64'h8877665544332211;
  localparam logic [63:0] MIN = 64'h8000000000000000;

  localparam vec_t VECS [N_VEC] = '{
    '{OP_EXT,      64'd3,                 PAT,          64'd0, 64'h44,               1'b1},
    '{OP_EXT,      64'hFFFFFFFFFFFFFFFF,  PAT,          64'd0, 64'h88,               1'b1},
    '{OP_MSK,      64'd0,                 PAT,          64'd0, 64'h8877665544332200, 1'b1},
    '{OP_MSK,      64'd7,                 PAT,          64'd0, 64'h0077665544332211, 1'b1},
    '{OP_INS,      64'd5,                 64'hAB,       64'd0, 64'h0000AB0000000000, 1'b1},
    '{OP_INS,      64'd8,                 64'hFFEE,     64'd0, 64'hEE,               1'b1},
    '{OP_OR,       64'hFF00,              64'h0F0F,     64'd0, 64'hFF0F,             1'b1},
    '{OP_CMOV_EQ,  64'd0,                 64'h1234,     64'd0, 64'h1234,             1'b1},
    '{OP_CMOV_EQ,  64'd0,                 64'h1234,     64'd1, 64'h1234,             1'b0},
    '{OP_CMOV_NE,  64'd0,                 64'h1234,     64'd5, 64'h1234,             1'b1},
    '{OP_CMOV_LT,  64'd0,                 64'h1234,     MIN,   64'h1234,             1'b1},
    '{OP_CMOV_GE,  64'd0,                 64'h1234,     MIN,   64'h1234,             1'b0},
    '{OP_CMOV_LE,  64'd0,                 64'h1234,     64'd0, 64'h1234,             1'b1},
    '{OP_CMOV_GT,  64'd0,                 64'h1234,     64'd0, 64'h1234,             1'b0},
    '{OP_CMOV_ODD, 64'd0,                 64'h1234,     64'd3, 64'h1234,             1'b1},
    '{OP_CMOV_EVN, 64'd0,                 64'h1234,     64'd3, 64'h1234,             1'b0},
    '{OP_S4ADD,    64'd3,                 64'd5,        64'd0, 64'h11,               1'b1},
    '{OP_S8ADD,    64'd3,                 64'd5,        64'd0, 64'h1D,               1'b1},
    '{OP_S4SUB,    64'd1,                 64'd5,        64'd0, 64'hFFFFFFFFFFFFFFFF, 1'b1},
    '{OP_S8SUB,    64'h2000000000000000,  64'd0,        64'd0, 64'h0,                1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0, c_i = '0;
  logic [63:0] result_o;
  logic        wen_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bxu_top u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .result_o (result_o),
    .wen_o    (wen_o)
  );

  function automatic string req_of(logic [3:0] op);
    if (op == 4'd0) return "R2";
    if (op == 4'd1) return "R3";
    if (op == 4'd2) return "R4";
    if (op == 4'd3) return "R5";
    if (op >= 4'd12) return "R8";
    return "R6";
  endfunction

  function automatic logic [64:0] ref_model(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c);
    int          sh;
    logic [63:0] r;
    logic        w;
    sh = int'(a[2:0]) * 8;
    w  = 1'b1;
    r  = b;
    case (op)
      4'd0:  r = (b >> sh) & 64'hFF;
      4'd1:  r = b & ~(64'hFF << sh);
      4'd2:  r = (b & 64'hFF) << sh;
      4'd3:  r = a | b;
      4'd4:  w = (c == 64'd0);
      4'd5:  w = (c != 64'd0);
      4'd6:  w = ($signed(c) < 0);
      4'd7:  w = ($signed(c) >= 0);
      4'd8:  w = ($signed(c) <= 0);
      4'd9:  w = ($signed(c) > 0);
      4'd10: w = c[0];
      4'd11: w = ~c[0];
      4'd12: r = a * 4 + b;
      4'd13: r = a * 8 + b;
      4'd14: r = a * 4 - b;
      default: r = a * 8 - b;
    endcase
    return {w, r};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, logic aw, logic ew);
    n_chk++;
    if (act !== exp || aw !== ew) begin
      n_bad++;
      $display("FAIL %s: result=%h wen=%b expected result=%h wen=%b", req, act, aw, exp, ew);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic [63:0] c);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; c_i = c;
    @(negedge clk);
  endtask

  initial begin
    logic [64:0] e;
    logic [63:0] prev;
    logic [63:0] ra, rb, rc;

    repeat (3) @(negedge clk);
    check("R1", result_o, 64'd0, wen_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c);
      check(VECS[i].op >= 4 && VECS[i].op <= 11 ? "R6" : (VECS[i].op < 4 ? req_of(VECS[i].op) : "R8"),
            result_o, VECS[i].exp, wen_o, VECS[i].wen);
    end

    // random sweep; lane offset rotates 0..7, R7 covered by wen on non-cmov ops
    for (int i = 0; i < N_RAND; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      ra[2:0] = 3'(i % 8);
      if (i % 5 == 0) rc = 64'd0;
      apply(4'(i % 16), ra, rb, rc);
      e = ref_model(4'(i % 16), ra, rb, rc);
      check((i % 16 < 4 || i % 16 > 11) ? {req_of(4'(i % 16)), "/R7"} : "R6",
            result_o, e[63:0], wen_o, e[64]);
    end

    // R9: output holds before the edge, updates right after it
    @(negedge clk);
    prev = result_o;
    op_i = OP_OR; a_i = 64'hF0; b_i = 64'h0F; c_i = '0;
    #5;
    check("R9", result_o, prev, wen_o, 1'b1);
    @(negedge clk);
    check("R9", result_o, 64'hFF, wen_o, 1'b1);
    op_i = OP_CMOV_NE; b_i = 64'hBEEF; c_i = 64'd0;
    @(negedge clk);
    check("R9", result_o, 64'hBEEF, wen_o, 1'b0);
    op_i = OP_EXT; a_i = 64'd6; b_i = PAT;
    @(negedge clk);
    check("R9", result_o, 64'h77, wen_o, 1'b1);

    // R1: asynchronous clear mid-run
    op_i = OP_MSK; a_i = 64'd2; b_i = PAT;
    #2;
    rst_ni = 1'b0;
    #2;
    check("R1", result_o, 64'd0, wen_o, 1'b0);
    @(negedge clk);
    check("R1", result_o, 64'd0, wen_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3", result_o, 64'h8877665544002211, wen_o, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule